// File: doc/BRIEF.md
# Tick Counter With Compare Interrupt

This block keeps a free-running count of enabled clock cycles and raises an interrupt when that count reaches a programmed compare value. Software reaches it through two registers, chosen by a one-bit select. Select 0 is the counter and select 1 is the compare register. Every access also carries a two-bit privilege level. Reads return data in the same cycle as the strobe. Writes take effect at the next rising clock edge. Illegal accesses raise one of two fault strobes in the same cycle and change no state.

The counter holds a 63-bit count and a trap flag. When the trap flag is set, user-level reads of the count are refused. The compare register holds a 63-bit target value and a disable flag. A small state machine tracks the compare. Its states are `CMP_OFF` (disabled), `CMP_ARMED` (waiting for a match), `CMP_FIRE` (the one-cycle interrupt state) and `CMP_SPENT` (matched, waiting for a new compare write). Its transitions are:

- Any state goes to `CMP_OFF` on a compare write with the disable flag set.
- Any state goes to `CMP_ARMED` on a compare write with the disable flag clear.
- `CMP_ARMED` goes to `CMP_FIRE` when the count equals the target.
- `CMP_FIRE` goes to `CMP_SPENT` on the next cycle.

A compare write takes priority over the match transition.

Privilege encoding on `priv_mode`: 2'b00 is user, 2'b01 is supervisor, and 2'b10 or 2'b11 is hypervisor.

Top module: `tick_timer`

## Requirements
- R1: Reset sets the following state:
  - The count is zero and the trap flag is set, so a hypervisor counter read returns 64'h8000_0000_0000_0000.
  - The compare register reads 64'h8000_0000_0000_0000, which means disabled with target 0.
  - `match_irq` is low.
- R2: The count changes only in cycles where `tick_en` is high and no counter load takes place. In each such cycle it rises by one. It wraps from 2^63-1 to 0, and the trap flag is unchanged when it wraps.
- R3: A permitted counter read returns the trap flag in bit 63 and the count in bits 62:0.
- R4: A hypervisor counter write has the following effects:
  - It loads bits 62:0 of `wr_data` as the count.
  - It loads bit 63 of `wr_data` as the trap flag.
  - The load wins over a tick in the same cycle.
- R5: A counter write with no effect raises one of two faults:
  - From user level it raises `fault_priv_opcode`.
  - From supervisor level it raises `fault_priv_action`.
- R6: A user-level counter read while the trap flag is set raises `fault_priv_action` and returns zero. With the trap flag clear, the same read is allowed and raises no fault.
- R7: Supervisor and hypervisor levels may write and read the compare register. Bit 63 is the disable flag and bits 62:0 are the target.
- R8: Any user-level compare access raises `fault_priv_opcode`. A user-level compare write leaves the register unchanged, and a user-level compare read returns zero.
- R9: With the disable flag clear, `match_irq` pulses for exactly one cycle, starting in the cycle after the one in which the count equals the target. It does not pulse again until the compare register is rewritten.
- R10: While the disable flag is set, `match_irq` stays low. Writing the compare register with the disable flag set cancels a pending match.
- R11: `rd_data` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable for this cycle |
| reg_sel | input | 1 | 0 selects the counter, 1 selects the compare register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 64 | Write data |
| priv_mode | input | 2 | Privilege level of the access |
| rd_data | output | 64 | Read data, valid in the cycle of the strobe |
| fault_priv_opcode | output | 1 | Access refused at user level |
| fault_priv_action | output | 1 | Access refused because of the trap flag or a supervisor counter write |
| match_irq | output | 1 | One-cycle compare interrupt |

## Verification
The hardest situations to reach from the ports involve the 63-bit count. A wrap would take 2^63 ticks, and a match far away would take just as long. The stimulus avoids this by loading the counter through a hypervisor write to a value just below the target or at 2^63-1, and then enabling a few ticks. The pulse position is checked cycle by cycle against the loaded value. A cancellation case arms the compare, ticks partway toward the target, and then rewrites the compare with the disable flag set before the count arrives. The bench then ticks past the target and checks that no pulse appears.

// File: rtl/tick_pkg.sv
package tick_pkg;
    typedef enum logic [1:0] {
        CMP_OFF   = 2'd0,
        CMP_ARMED = 2'd1,
        CMP_FIRE  = 2'd2,
        CMP_SPENT = 2'd3
    } cmp_state_e;

    localparam logic [1:0] PRIV_USER  = 2'd0;
    localparam logic [1:0] PRIV_SUPER = 2'd1;
    localparam logic       SEL_COUNT  = 1'b0;
    localparam logic       SEL_CMP    = 1'b1;
endpackage

// File: rtl/tick_count.sv
module tick_count #(
    parameter int W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    output logic [W-2:0]     cnt,
    output logic             trap
);
    localparam int VAL_W = W - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            trap <= 1'b1;
        end else if (load) begin
            cnt  <= load_val[VAL_W-1:0];
            trap <= load_val[W-1];
        end else if (tick_en) begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R2: one step per enabled cycle, modulo 2^63
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tick_en) && !$past(load)
        |-> cnt == VAL_W'($past(cnt) + 1'b1));

    // R2: no enable, no load -> nothing moves
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(tick_en) && !$past(load)
        |-> $stable(cnt) && $stable(trap));

    // R4: load takes the written word, tick or not
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(load) |-> {trap, cnt} == $past(load_val));
endmodule

// File: rtl/tick_compare.sv
module tick_compare
    import tick_pkg::*;
#(
    parameter int W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [W-1:0]     wr_val,
    input  logic [W-2:0]     cnt,
    output logic [W-1:0]     cmp_reg,
    output logic             irq
);
    localparam int VAL_W = W - 1;

    cmp_state_e state_q, state_d;
    logic       hit;

    assign hit = (cnt == cmp_reg[VAL_W-1:0]);

    always_comb begin
        state_d = state_q;
        if (wr) begin
            state_d = wr_val[W-1] ? CMP_OFF : CMP_ARMED;
        end else begin
            unique case (state_q)
                CMP_OFF:   state_d = CMP_OFF;
                CMP_ARMED: state_d = hit ? CMP_FIRE : CMP_ARMED;
                CMP_FIRE:  state_d = CMP_SPENT;
                CMP_SPENT: state_d = CMP_SPENT;
                default:   state_d = CMP_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CMP_OFF;
            cmp_reg <= {1'b1, {VAL_W{1'b0}}};
        end else begin
            state_q <= state_d;
            if (wr) cmp_reg <= wr_val;
        end
    end

    always_comb begin
        irq = (state_q == CMP_FIRE);
    end

    // R9: the pulse lasts one cycle
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: a pulse follows a cycle where count met an enabled target
    a_r9_source: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && irq
        |-> $past(cnt) == cmp_reg[VAL_W-1:0] && !cmp_reg[W-1]);

    // R10: disabled compare never interrupts
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_reg[W-1] |-> !irq);

    // R10: a disabling write cancels any pending match
    a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr) && $past(wr_val[W-1]) |-> !irq);
endmodule

// File: rtl/tick_access.sv
module tick_access
    import tick_pkg::*;
(
    input  logic       sel,
    input  logic       wr,
    input  logic       rd,
    input  logic [1:0] priv,
    input  logic       trap,
    output logic       cnt_load,
    output logic       cmp_load,
    output logic       rd_block,
    output logic       f_opcode,
    output logic       f_action
);
    logic is_user, is_super, is_hyper;

    always_comb begin
        is_user  = (priv == PRIV_USER);
        is_super = (priv == PRIV_SUPER);
        is_hyper = priv[1];

        cnt_load = wr && (sel == SEL_COUNT) && is_hyper;
        cmp_load = wr && (sel == SEL_CMP) && !is_user;
        rd_block = is_user && ((sel == SEL_CMP) || trap);

        f_opcode = is_user && (wr || (rd && (sel == SEL_CMP)));
        f_action = (wr && (sel == SEL_COUNT) && is_super)
                || (rd && (sel == SEL_COUNT) && is_user && trap);
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [W-1:0]     wr_data,
    input  logic [1:0]       priv_mode,
    output logic [W-1:0]     rd_data,
    output logic             fault_priv_opcode,
    output logic             fault_priv_action,
    output logic             match_irq
);
    localparam int VAL_W = W - 1;

    logic [VAL_W-1:0] cnt;
    logic             trap;
    logic [W-1:0]     cmp_reg;
    logic             cnt_load, cmp_load, rd_block;

    tick_access u_access (
        .sel      (reg_sel),
        .wr       (wr_en),
        .rd       (rd_en),
        .priv     (priv_mode),
        .trap     (trap),
        .cnt_load (cnt_load),
        .cmp_load (cmp_load),
        .rd_block (rd_block),
        .f_opcode (fault_priv_opcode),
        .f_action (fault_priv_action)
    );

    tick_count #(.W(W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (cnt_load),
        .load_val (wr_data),
        .cnt      (cnt),
        .trap     (trap)
    );

    tick_compare #(.W(W)) u_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cmp_load),
        .wr_val  (wr_data),
        .cnt     (cnt),
        .cmp_reg (cmp_reg),
        .irq     (match_irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en && !rd_block) begin
            rd_data = (reg_sel == SEL_COUNT) ? {trap, cnt} : cmp_reg;
        end
    end

    // R5/R8: opcode faults come only from user level
    a_r5_opcode_user: assert property (@(posedge clk) disable iff (!rst_n)
        fault_priv_opcode |-> priv_mode == PRIV_USER);

    // R8: user compare write leaves the compare register alone
    a_r8_cmp_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en && reg_sel == SEL_CMP && priv_mode == PRIV_USER)
        |-> $stable(cmp_reg));

    // R6: a refused user counter read returns zero
    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fault_priv_action && rd_en && reg_sel == SEL_COUNT && priv_mode == PRIV_USER
        |-> rd_data == '0);

    // R11: idle read port drives zero
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);
endmodule

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
    localparam int W     = 64;
    localparam int VEC_W = 135;
    localparam int NVEC  = 13;
    localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;

    // {sel, wr, rd, priv[1:0], wdata[63:0], exp_rd[63:0], exp_opc, exp_act}
    localparam logic [VEC_W-1:0] VEC [0:NVEC-1] = '{
        {1'b0,1'b0,1'b1,2'd2,64'h0,   TOP,   1'b0,1'b0}, // R1 R3 count after reset
        {1'b0,1'b0,1'b1,2'd0,64'h0,   64'h0, 1'b0,1'b1}, // R6 trap set, user read
        {1'b0,1'b1,1'b0,2'd0,64'h5,   64'h0, 1'b1,1'b0}, // R5 user counter write
        {1'b0,1'b1,1'b0,2'd1,64'h5,   64'h0, 1'b0,1'b1}, // R5 supervisor counter write
        {1'b0,1'b0,1'b1,2'd1,64'h0,   TOP,   1'b0,1'b0}, // R5 count unchanged
        {1'b0,1'b1,1'b0,2'd2,64'h123, 64'h0, 1'b0,1'b0}, // R4 hypervisor load
        {1'b0,1'b0,1'b1,2'd0,64'h0,   64'h123,1'b0,1'b0},// R6 trap clear, user read ok
        {1'b1,1'b1,1'b0,2'd0,64'h200, 64'h0, 1'b1,1'b0}, // R8 user compare write
        {1'b1,1'b0,1'b1,2'd1,64'h0,   TOP,   1'b0,1'b0}, // R8 R1 compare unchanged
        {1'b1,1'b0,1'b1,2'd0,64'h0,   64'h0, 1'b1,1'b0}, // R8 user compare read
        {1'b1,1'b1,1'b0,2'd1,TOP|64'h777,64'h0,1'b0,1'b0},// R7 supervisor compare write
        {1'b1,1'b0,1'b1,2'd2,64'h0,   TOP|64'h777,1'b0,1'b0},// R7 hypervisor read
        {1'b0,1'b0,1'b0,2'd2,64'h0,   64'h0, 1'b0,1'b0}  // R11 idle port
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tick_en, reg_sel, wr_en, rd_en;
    logic [W-1:0] wr_data;
    logic [1:0]   priv_mode;
    logic [W-1:0] rd_data;
    logic         fault_priv_opcode, fault_priv_action, match_irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tick_timer #(.W(W)) dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .tick_en           (tick_en),
        .reg_sel           (reg_sel),
        .wr_en             (wr_en),
        .rd_en             (rd_en),
        .wr_data           (wr_data),
        .priv_mode         (priv_mode),
        .rd_data           (rd_data),
        .fault_priv_opcode (fault_priv_opcode),
        .fault_priv_action (fault_priv_action),
        .match_irq         (match_irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [1:0] pm, input logic [63:0] d);
        @(negedge clk);
        reg_sel = sel; priv_mode = pm; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, input logic [1:0] pm, output logic [63:0] d);
        @(negedge clk);
        reg_sel = sel; priv_mode = pm; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] v;
        rst_n = 1'b0; tick_en = 1'b0; reg_sel = 1'b0; wr_en = 1'b0;
        rd_en = 1'b0; wr_data = '0; priv_mode = 2'd2;
        repeat (3) @(negedge clk);
        check("R1 irq low in reset", {63'd0, match_irq}, 64'd0);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            reg_sel   = VEC[i][134];
            wr_en     = VEC[i][133];
            rd_en     = VEC[i][132];
            priv_mode = VEC[i][131:130];
            wr_data   = VEC[i][129:66];
            #1;
            if (VEC[i][132] || !VEC[i][133])
                check($sformatf("R3/R6/R7/R8/R11 row %0d rd_data", i), rd_data, VEC[i][65:2]);
            check($sformatf("R5/R6/R8 row %0d opcode fault", i), {63'd0, fault_priv_opcode}, {63'd0, VEC[i][1]});
            check($sformatf("R5/R6 row %0d action fault", i), {63'd0, fault_priv_action}, {63'd0, VEC[i][0]});
            check($sformatf("R10 row %0d irq low", i), {63'd0, match_irq}, 64'd0);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;

        // R2: five ticks
        wr_reg(1'b0, 2'd2, 64'd10);
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        rd_reg(1'b0, 2'd2, v);
        check("R2 five ticks", v, 64'd15);
        repeat (3) @(negedge clk);
        rd_reg(1'b0, 2'd2, v);
        check("R2 hold without enable", v, 64'd15);

        // R2: wrap
        wr_reg(1'b0, 2'd2, 64'h7FFF_FFFF_FFFF_FFFF);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        rd_reg(1'b0, 2'd2, v);
        check("R2 wrap to zero", v, 64'd0);

        // R4: load beats tick (trap set via bit 63)
        tick_en = 1'b1;
        wr_reg(1'b0, 2'd2, TOP | 64'd100);
        tick_en = 1'b0;
        rd_reg(1'b0, 2'd2, v);
        check("R4 load over tick, trap from bit 63", v, TOP | 64'd100);

        // R9: pulse one cycle after count reaches 25
        wr_reg(1'b0, 2'd2, 64'd20);
        wr_reg(1'b1, 2'd1, 64'd25);
        tick_en = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            check($sformatf("R9 irq at tick %0d", k), {63'd0, match_irq}, {63'd0, (k == 6)});
        end
        tick_en = 1'b0;

        // R10: cancel a pending match
        wr_reg(1'b0, 2'd2, 64'd40);
        wr_reg(1'b1, 2'd2, 64'd45);
        tick_en = 1'b1;
        repeat (2) @(negedge clk);
        tick_en = 1'b0;
        wr_reg(1'b1, 2'd1, TOP | 64'd45);
        tick_en = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            check($sformatf("R10 cancelled, tick %0d", k), {63'd0, match_irq}, 64'd0);
        end
        tick_en = 1'b0;
        rd_reg(1'b0, 2'd2, v);
        check("R2 count after cancel run", v, 64'd52);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule